// File: doc/BRIEF.md
# Lockable Comparator Control Bank

This block holds the configuration for a group of analog comparator channels and turns each channel's raw digital level into a conditioned output. Software reaches it through a simple APB-style bus. Each channel has one 32-bit control word. The word holds these fields:

- an enable bit
- the two input-selector codes
- a hysteresis code
- an output-inversion bit
- a blanking-source select
- two enables for the shared reference-scaler circuitry
- a read-only flag that mirrors the raw level
- a lock bit that freezes the word

The analog macros, the reference ladder and the pin multiplexers sit outside this block. They take the selector, hysteresis and scaler settings from dedicated output ports.

Each raw level reaches the output through a purely combinational path. The path applies the inversion bit, masks the level with one of seven timer pulses chosen per channel, and forces the output low while the channel is disabled. This path therefore keeps working when the bus clock is stopped. A separate two-flop synchronized copy of the raw level feeds the status flag that software reads back. Once a channel's lock bit is set, its word cannot be changed until the next reset. This guards the safety-relevant setup against stray bus writes.

Top module: `cmp_ctrl_bank`

## Requirements
- R1: After reset every channel word reads 0x0000_0000, every conditioned output is 0, and both shared scaler enables are 0.
- R2: Channel n (0 to 6) sits at byte offset 4*n. Its word uses these bit positions: 31 lock, 30 raw-level flag (read-only), 23 scaler enable, 22 bridge enable, 21:19 blanking select, 18:16 hysteresis code, 15 invert, 8 positive-input select, 6:4 negative-input select, 0 enable. Every other bit reads 0, so writing 0x7FFF_FFFF with the raw level low reads back 0x00FF_8171.
- R3: Once a write sets bit 31, every later write to that word has no effect, including writes that try to clear bit 31. The lock is cleared only by reset. Words of other channels stay writable.
- R4: Bit 30 reads the raw level after a two-flop synchronizer. A level change that is applied between clock edges appears after the second rising edge, not after the first. The flag ignores the invert bit and the blanking gate.
- R5: For an enabled channel with no blanking, the conditioned output equals the raw level when the invert bit is 0, and the inverted raw level when it is 1. The output follows the raw level combinationally.
- R6: Blanking select code k (1 to 7) takes timer pulse input bit k-1. The output is 0 while that pulse is high and is unaffected by the other pulses. Code 0 selects no blanking.
- R7: When bit 0 is clear, the channel's conditioned output is 0 and bit 30 reads 0, whatever the raw level and the invert bit.
- R8: The shared scaler enable output is 1 while bit 23 is set in any channel word, and 0 only when it is clear in all of them. The bridge enable output follows bit 22 the same way.
- R9: Offsets 0x1C and above read 0. Writes to them change no channel word.
- R10: The per-channel enable, positive-select, negative-select and hysteresis output ports carry the stored field values. Channel n occupies bit n, or bits 3n+2:3n of the 3-bit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in sync with clk |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | 5 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| raw_lvl | input | 7 | Raw level of each comparator |
| blank_pulse | input | 7 | Timer blanking pulses; bit k-1 is source code k |
| cond_out | output | 7 | Conditioned output of each channel |
| ch_en | output | 7 | Enable bit of each channel |
| inp_sel | output | 7 | Positive-input select of each channel |
| inm_sel | output | 21 | Negative-input select, 3 bits per channel |
| hyst_code | output | 21 | Hysteresis code, 3 bits per channel |
| scaler_en | output | 1 | OR of all scaler enable bits |
| bridge_en | output | 1 | OR of all bridge enable bits |

## Verification
The bench tries to rewrite a locked word twice, once with zero and once with all ones. A lock that is not sticky, or that guards only some fields, shows up as a changed read-back or a changed enable port. It reads the status flag after one edge and again after two. A design with too few synchronizer stages, or one that feeds the flag from the inverted or blanked level, returns the wrong value at one of those points. It walks every blanking code against a single-hot pulse and against its complement. This catches an off-by-one source index and the case where code 0 takes a pulse. It also clears the scaler bits one channel at a time to expose an enable that follows only the last word written.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;   // width of the 3-bit selector fields

  // bit positions decoded by software
  localparam int B_LOCK = 31;
  localparam int B_VAL  = 30;
  localparam int B_SCL  = 23;
  localparam int B_BRG  = 22;
  localparam int B_BLKL = 19;
  localparam int B_HYSL = 16;
  localparam int B_POL  = 15;
  localparam int B_INP  = 8;
  localparam int B_INML = 4;
  localparam int B_EN   = 0;

  typedef struct packed {
    logic             lock;
    logic             scl;
    logic             brg;
    logic [SEL_W-1:0] blk;
    logic [SEL_W-1:0] hys;
    logic             pol;
    logic             inp;
    logic [SEL_W-1:0] inm;
    logic             en;
  } chan_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(chan_cfg_t c, logic val);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_LOCK]                  = c.lock;
    w[B_VAL]                   = val;
    w[B_SCL]                   = c.scl;
    w[B_BRG]                   = c.brg;
    w[B_BLKL +: SEL_W]         = c.blk;
    w[B_HYSL +: SEL_W]         = c.hys;
    w[B_POL]                   = c.pol;
    w[B_INP]                   = c.inp;
    w[B_INML +: SEL_W]         = c.inm;
    w[B_EN]                    = c.en;
    return w;
  endfunction

  function automatic chan_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.lock = w[B_LOCK];
    c.scl  = w[B_SCL];
    c.brg  = w[B_BRG];
    c.blk  = w[B_BLKL +: SEL_W];
    c.hys  = w[B_HYSL +: SEL_W];
    c.pol  = w[B_POL];
    c.inp  = w[B_INP];
    c.inm  = w[B_INML +: SEL_W];
    c.en   = w[B_EN];
    return c;
  endfunction

endpackage

// File: rtl/cmp_chan_reg.sv
// One channel's configuration word with a self-locking write guard.
module cmp_chan_reg
  import cmp_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  chan_cfg_t wr_cfg,
  output chan_cfg_t cfg_q
);

  chan_cfg_t cfg_d;
  logic      load;

  // next state: a write lands only while the word is still open
  always_comb begin
    load  = wr_hit && !cfg_q.lock;
    cfg_d = load ? wr_cfg : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (load)
      cfg_q <= cfg_d;
  end

  // R3: lock is sticky and the word never moves once locked
  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> cfg_q.lock);
  a_r3_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable(cfg_q));

endmodule

// File: rtl/cmp_lvl_sync.sv
// Two-stage synchronizer for the raw comparator levels (status path only).
module cmp_lvl_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q;
  logic [W-1:0] s1_d, q_d;

  always_comb begin
    s1_d = d;
    q_d  = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= s1_d;
      q    <= q_d;
    end
  end

  // checker support: edges seen since reset, saturating at two
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      age_q <= '0;
    else if (age_q != 2'd2)
      age_q <= age_q + 2'd1;
  end

  // R4: the synchronized copy lags the input by exactly two edges
  a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/cmp_out_cond.sv
// Combinational output conditioning: enable, inversion and blanking gate.
module cmp_out_cond
  import cmp_ctrl_pkg::*;
#(
  parameter int NSRC = (1 << SEL_W) - 1
) (
  input  logic             raw,
  input  logic             en,
  input  logic             pol,
  input  logic [SEL_W-1:0] blk_sel,
  input  logic [NSRC-1:0]  pulses,
  output logic             y
);

  logic blank;
  logic lvl;

  always_comb begin
    blank = 1'b0;                  // code 0: nothing selected
    for (int s = 0; s < NSRC; s++) begin
      if (blk_sel == SEL_W'(s + 1))
        blank = pulses[s];
    end
    lvl = raw ^ pol;
    y   = en & lvl & ~blank;
  end

endmodule

// File: rtl/cmp_ctrl_bank.sv
// Configuration bank and output conditioning for a group of comparators.
// rst_n is expected to come from an upstream reset synchronizer.
module cmp_ctrl_bank
  import cmp_ctrl_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [4:0]           paddr,
  input  logic [WORD_W-1:0]    pwdata,
  output logic [WORD_W-1:0]    prdata,
  input  logic [NCH-1:0]       raw_lvl,
  input  logic [6:0]           blank_pulse,
  output logic [NCH-1:0]       cond_out,
  output logic [NCH-1:0]       ch_en,
  output logic [NCH-1:0]       inp_sel,
  output logic [NCH*SEL_W-1:0] inm_sel,
  output logic [NCH*SEL_W-1:0] hyst_code,
  output logic                 scaler_en,
  output logic                 bridge_en
);

  localparam int NSRC  = (1 << SEL_W) - 1;
  localparam int ADR_W = 5;
  localparam int IDX_W = ADR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_go;
  logic [NCH-1:0]   wr_hit;
  chan_cfg_t        wr_cfg;
  chan_cfg_t        cfg_q [NCH];
  logic [NCH-1:0]   lvl_sync;
  logic [NCH-1:0]   val;

  // bus decode
  always_comb begin
    idx    = paddr[ADR_W-1:2];
    wr_go  = psel && penable && pwrite;
    wr_cfg = word_to_cfg(pwdata);
    for (int i = 0; i < NCH; i++)
      wr_hit[i] = wr_go && (idx == IDX_W'(i));
  end

  // bits no field decodes
  logic unused_bus;
  assign unused_bus = ^{paddr[1:0], pwdata[29:24], pwdata[14:9], pwdata[7], pwdata[3:1]};

  cmp_lvl_sync #(.W(NCH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_lvl),
    .q     (lvl_sync)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cmp_chan_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[i]),
      .wr_cfg (wr_cfg),
      .cfg_q  (cfg_q[i])
    );

    cmp_out_cond #(.NSRC(NSRC)) u_cond (
      .raw     (raw_lvl[i]),
      .en      (cfg_q[i].en),
      .pol     (cfg_q[i].pol),
      .blk_sel (cfg_q[i].blk),
      .pulses  (blank_pulse),
      .y       (cond_out[i])
    );

    assign val[i]                      = lvl_sync[i] & cfg_q[i].en;
    assign ch_en[i]                    = cfg_q[i].en;
    assign inp_sel[i]                  = cfg_q[i].inp;
    assign inm_sel[i*SEL_W +: SEL_W]   = cfg_q[i].inm;
    assign hyst_code[i*SEL_W +: SEL_W] = cfg_q[i].hys;

    // R5: unblanked enabled channel follows raw level through the inversion bit
    a_r5_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i].en && cfg_q[i].blk == '0) |-> (cond_out[i] == (raw_lvl[i] ^ cfg_q[i].pol)));
    // R7: a disabled channel drives nothing
    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[i].en |-> !cond_out[i]);
  end

  // read mux and shared enables
  always_comb begin
    prdata    = '0;
    scaler_en = 1'b0;
    bridge_en = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (psel && idx == IDX_W'(i))
        prdata = cfg_to_word(cfg_q[i], val[i]);
      scaler_en = scaler_en | cfg_q[i].scl;
      bridge_en = bridge_en | cfg_q[i].brg;
    end
  end

  // R9: offsets past the last channel read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && idx >= IDX_W'(NCH)) |-> (prdata == '0));

endmodule

// File: tb/tb_cmp_ctrl_bank.sv
module tb_cmp_ctrl_bank;

  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [6:0]  raw_lvl, blank_pulse, cond_out, ch_en, inp_sel;
  logic [20:0] inm_sel, hyst_code;
  logic        scaler_en, bridge_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  cmp_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .raw_lvl(raw_lvl),
    .blank_pulse(blank_pulse), .cond_out(cond_out), .ch_en(ch_en),
    .inp_sel(inp_sel), .inm_sel(inm_sel), .hyst_code(hyst_code),
    .scaler_en(scaler_en), .bridge_en(bridge_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    #1 d = prdata;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // R1
  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < 7; c++) begin
      bus_rd(5'(4 * c), d);
      chk_eq("R1 word after reset", d, 32'h0);
    end
    chk_eq("R1 outputs after reset", {25'h0, cond_out}, 32'h0);
    chk_eq("R1 scaler enables after reset", {30'h0, scaler_en, bridge_en}, 32'h0);
  endtask

  // R2
  task automatic t_layout;
    logic [31:0] d;
    bus_wr(5'h04, 32'h7FFF_FFFF);
    bus_rd(5'h04, d);
    chk_eq("R2 reserved bits read zero", d, 32'h00FF_8171);
    bus_wr(5'h04, 32'h0);
    bus_rd(5'h04, d);
    chk_eq("R2 cleared word", d, 32'h0);
  endtask

  // R10
  task automatic t_cfg_ports;
    logic [31:0] d;
    bus_wr(5'h08, 32'h0006_0151);
    chk_eq("R10 enable port", {31'h0, ch_en[2]}, 32'h1);
    chk_eq("R10 positive select port", {31'h0, inp_sel[2]}, 32'h1);
    chk_eq("R10 negative select port", {29'h0, inm_sel[8:6]}, 32'h5);
    chk_eq("R10 hysteresis port", {29'h0, hyst_code[8:6]}, 32'h6);
    bus_rd(5'h08, d);
    chk_eq("R2 readback of fields", d, 32'h0006_0151);
    bus_wr(5'h08, 32'h0);
  endtask

  // R4 R5
  task automatic t_polarity_value;
    logic [31:0] d;
    bus_wr(5'h00, 32'h1);
    #1 chk_eq("R5 raw low not inverted", {31'h0, cond_out[0]}, 32'h0);
    @(negedge clk); raw_lvl[0] = 1;
    #1 chk_eq("R5 raw high not inverted", {31'h0, cond_out[0]}, 32'h1);
    bus_rd(5'h00, d);
    chk_eq("R4 flag after one edge", {31'h0, d[30]}, 32'h0);
    bus_rd(5'h00, d);
    chk_eq("R4 flag after sync", {31'h0, d[30]}, 32'h1);
    bus_wr(5'h00, 32'h0000_8001);
    #1 chk_eq("R5 raw high inverted", {31'h0, cond_out[0]}, 32'h0);
    bus_rd(5'h00, d);
    chk_eq("R4 flag ignores inversion", d, 32'h4000_8001);
    @(negedge clk); raw_lvl[0] = 0;
    #1 chk_eq("R5 raw low inverted", {31'h0, cond_out[0]}, 32'h1);
  endtask

  // R7
  task automatic t_disable;
    logic [31:0] d;
    bus_wr(5'h00, 32'h0000_8000);
    #1 chk_eq("R7 disabled output with inversion", {31'h0, cond_out[0]}, 32'h0);
    raw_lvl[0] = 1;
    repeat (3) @(negedge clk);
    chk_eq("R7 disabled output raw high", {31'h0, cond_out[0]}, 32'h0);
    bus_rd(5'h00, d);
    chk_eq("R7 flag reads zero when disabled", d, 32'h0000_8000);
    raw_lvl[0] = 0;
    bus_wr(5'h00, 32'h0);
  endtask

  // R6
  task automatic t_blank;
    raw_lvl[3] = 1;
    for (int k = 1; k <= 7; k++) begin
      bus_wr(5'h0C, (32'(k) << 19) | 32'h1);
      blank_pulse = 7'(1 << (k - 1));
      #1 chk_eq($sformatf("R6 code %0d own pulse blanks", k), {31'h0, cond_out[3]}, 32'h0);
      blank_pulse = ~7'(1 << (k - 1));
      #1 chk_eq($sformatf("R6 code %0d other pulses pass", k), {31'h0, cond_out[3]}, 32'h1);
    end
    bus_wr(5'h0C, 32'h1);
    blank_pulse = 7'h7F;
    #1 chk_eq("R6 code 0 no blanking", {31'h0, cond_out[3]}, 32'h1);
    blank_pulse = 0;
    raw_lvl[3] = 0;
    bus_wr(5'h0C, 32'h0);
  endtask

  // R8
  task automatic t_scaler;
    bus_wr(5'h10, 32'h0080_0000);
    chk_eq("R8 one scaler bit", {30'h0, scaler_en, bridge_en}, 32'h2);
    bus_wr(5'h14, 32'h00C0_0000);
    chk_eq("R8 both set", {30'h0, scaler_en, bridge_en}, 32'h3);
    bus_wr(5'h10, 32'h0);
    chk_eq("R8 scaler held by other channel", {30'h0, scaler_en, bridge_en}, 32'h3);
    bus_wr(5'h14, 32'h0040_0000);
    chk_eq("R8 scaler drops when all clear", {30'h0, scaler_en, bridge_en}, 32'h1);
    bus_wr(5'h14, 32'h0);
    chk_eq("R8 bridge drops when all clear", {30'h0, scaler_en, bridge_en}, 32'h0);
  endtask

  // R9
  task automatic t_unmapped;
    logic [31:0] d;
    bus_wr(5'h1C, 32'hFFFF_FFFF);
    bus_rd(5'h1C, d);
    chk_eq("R9 unmapped reads zero", d, 32'h0);
    bus_rd(5'h18, d);
    chk_eq("R9 last channel untouched", d, 32'h0);
    bus_rd(5'h00, d);
    chk_eq("R9 first channel untouched", d, 32'h0);
    chk_eq("R9 ports untouched", {7'h0, ch_en, scaler_en, bridge_en, 16'h0}, 32'h0);
  endtask

  // R3
  task automatic t_lock;
    logic [31:0] d;
    bus_wr(5'h18, 32'h8000_8001);
    bus_rd(5'h18, d);
    chk_eq("R3 locked word", d, 32'h8000_8001);
    bus_wr(5'h18, 32'h0);
    bus_rd(5'h18, d);
    chk_eq("R3 zero write ignored", d, 32'h8000_8001);
    bus_wr(5'h18, 32'h7FFF_FFFF);
    bus_rd(5'h18, d);
    chk_eq("R3 ones write ignored", d, 32'h8000_8001);
    chk_eq("R3 locked enable port", {31'h0, ch_en[6]}, 32'h1);
    chk_eq("R3 locked inversion still active", {31'h0, cond_out[6]}, 32'h1);
    chk_eq("R3 locked scaler not set", {30'h0, scaler_en, bridge_en}, 32'h0);
    bus_wr(5'h00, 32'h0000_0001);
    bus_rd(5'h00, d);
    chk_eq("R3 other channel writable", d, 32'h0000_0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      report();
    end
  end

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    raw_lvl = 0; blank_pulse = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_layout();
    t_cfg_ports();
    t_polarity_value();
    t_disable();
    t_blank();
    t_scaler();
    t_unmapped();
    t_lock();
    done = 1;
    report();
  end

endmodule